// File: doc/BRIEF.md
# Shared Smooth Frequency Transition Arbiter

Two frequency synthesizer channels, a CPU channel and an SRC channel, each take a divider value N from a programmed target. This block holds the divider value that is live on each channel. There is only one ramp engine, and only one channel can use it at a time. The channel that owns the engine walks its live N toward a new target one unit per rate tick, so the output frequency changes gradually. The other channel copies its target straight into its live value on the next clock, which is an abrupt change.

Ownership is assigned in one of two ways. In automatic mode the engine goes to the channel whose target has changed, and the CPU channel takes priority when both change together. In manual mode a select bit names the owning channel. While a ramp is in progress the busy flag is high and the engine stays with its current owner. Mode and select inputs are only looked at again once the engine is idle.

Top module: `sft_arbiter`

## Requirements
- R1: After synchronous reset, both live values are 0 and busy is 0.
- R2: The owning channel's live value moves by exactly one per clock on which rate_tick is 1, upward when the target is above it and downward when the target is below it.
- R3: Busy is 1 after every clock edge that leaves the owned channel's live value different from its target, and 0 once the two are equal.
- R4: On a clock with rate_tick at 0, the owned channel's live value does not change.
- R5: In automatic mode (mode_manual = 0), an idle engine goes to the SRC channel (select value 1) when only the SRC target differs from its live value.
- R6: In automatic mode, when both targets differ from their live values on the same idle clock, the CPU channel (select value 0) gets the engine and the SRC live value takes its target on the next edge.
- R7: The channel that does not own the engine copies its target into its live value on the next clock edge, even while the other channel is ramping.
- R8: While busy is 1, a change of mode_manual or manual_sel does not move the engine to the other channel.
- R9: In manual mode (mode_manual = 1), only the channel named by manual_sel (0 = CPU, 1 = SRC) ramps; a target change on the other channel is applied abruptly.
- R10: If the owner's target changes during a ramp, stepping continues from the present live value toward the new target.
- R11: A target equal to the present live value leaves busy at 0 and the live value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_target | input | N_W | Programmed N for the CPU channel |
| src_target | input | N_W | Programmed N for the SRC channel |
| mode_manual | input | 1 | 0 = automatic ownership, 1 = manual ownership |
| manual_sel | input | 1 | Owner in manual mode: 0 = CPU, 1 = SRC |
| rate_tick | input | 1 | One-cycle pulse that permits one ramp step |
| cpu_live | output | N_W | Live N of the CPU channel |
| src_live | output | N_W | Live N of the SRC channel |
| busy | output | 1 | Ramp engine is in use |

## Verification
The bench builds the block with N_W = 5, which gives 32 divider values. With that width the CPU channel can be ramped through every ordered pair of start and end values, so every step distance is covered in both directions, including zero and the full span. The small width also keeps a mid-ramp retarget, a manual-select flip during a ramp, and a simultaneous request from both channels short enough to check one cycle at a time against the expected values.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_CPU = 1'b0,
        CH_SRC = 1'b1
    } chan_e;

    typedef struct packed {
        logic  engaged;
        chan_e owner;
    } grant_t;

    function automatic chan_e auto_pick(input logic [NUM_CH-1:0] differs);
        return differs[CH_CPU] ? CH_CPU : CH_SRC;
    endfunction

endpackage

// File: rtl/sft_grant.sv
module sft_grant
    import sft_pkg::*;
(
    input  logic              busy_q,
    input  chan_e             owner_q,
    input  logic              manual_mode,
    input  chan_e             manual_owner,
    input  logic [NUM_CH-1:0] differs,
    output grant_t            grant
);
    chan_e sel;

    always_comb begin
        if (busy_q) begin
            sel = owner_q;
        end else if (manual_mode) begin
            sel = manual_owner;
        end else begin
            sel = auto_pick(differs);
        end
        grant.owner   = sel;
        grant.engaged = differs[sel];
    end
endmodule

// File: rtl/sft_lane.sv
module sft_lane #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] target,
    input  logic         owned,
    input  logic         rate_tick,
    output logic [W-1:0] live,
    output logic         differs,
    output logic         pending
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] live_q;
    logic [W-1:0] live_d;

    always_comb begin
        differs = (target != live_q);
        if (!owned) begin
            live_d = target;
        end else if (rate_tick && differs) begin
            live_d = (target > live_q) ? (live_q + ONE) : (live_q - ONE);
        end else begin
            live_d = live_q;
        end
        pending = (live_d != target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign live = live_q;
endmodule

// File: rtl/sft_arbiter.sv
module sft_arbiter
    import sft_pkg::*;
#(
    parameter int N_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] cpu_target,
    input  logic [N_W-1:0] src_target,
    input  logic           mode_manual,
    input  logic           manual_sel,
    input  logic           rate_tick,
    output logic [N_W-1:0] cpu_live,
    output logic [N_W-1:0] src_live,
    output logic           busy
);
    logic [N_W-1:0]    tgt  [NUM_CH];
    logic [N_W-1:0]    live [NUM_CH];
    logic [NUM_CH-1:0] differs;
    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] owned;
    grant_t            grant;
    logic              busy_q;
    chan_e             owner_q;

    assign tgt[CH_CPU] = cpu_target;
    assign tgt[CH_SRC] = src_target;

    sft_grant u_grant (
        .busy_q      (busy_q),
        .owner_q     (owner_q),
        .manual_mode (mode_manual),
        .manual_owner(chan_e'(manual_sel)),
        .differs     (differs),
        .grant       (grant)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign owned[c] = grant.engaged && (grant.owner == chan_e'(c));
        sft_lane #(.W(N_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .target   (tgt[c]),
            .owned    (owned[c]),
            .rate_tick(rate_tick),
            .live     (live[c]),
            .differs  (differs[c]),
            .pending  (pending[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            owner_q <= CH_CPU;
        end else begin
            busy_q <= grant.engaged && pending[grant.owner];
            if (!busy_q) begin
                owner_q <= grant.owner;
            end
        end
    end

    assign cpu_live = live[CH_CPU];
    assign src_live = live[CH_SRC];
    assign busy     = busy_q;
endmodule

// File: rtl/sft_arbiter_chk.sv
module sft_arbiter_chk #(
    parameter int N_W = 9
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           owner,
    input logic           rate_tick,
    input logic [N_W-1:0] cpu_live,
    input logic [N_W-1:0] src_live,
    input logic [N_W-1:0] cpu_target,
    input logic [N_W-1:0] src_target
);
    logic [N_W-1:0] own_live;
    logic [N_W-1:0] oth_live;
    logic [N_W-1:0] oth_tgt;

    assign own_live = owner ? src_live : cpu_live;
    assign oth_live = owner ? cpu_live : src_live;
    assign oth_tgt  = owner ? cpu_target : src_target;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !rate_tick) |=> (own_live == $past(own_live))); // R4

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && rate_tick) |=> ((own_live == $past(own_live))
                              || (own_live == $past(own_live) + N_W'(1))
                              || (own_live == $past(own_live) - N_W'(1)))); // R2

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> (owner == $past(owner))); // R8

    AST_NONOWNER_JUMP: assert property (@(posedge clk) disable iff (rst)
        busy |=> (oth_live == $past(oth_tgt))); // R7
endmodule

bind sft_arbiter sft_arbiter_chk #(.N_W(N_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy_q),
    .owner     (owner_q),
    .rate_tick (rate_tick),
    .cpu_live  (cpu_live),
    .src_live  (src_live),
    .cpu_target(cpu_target),
    .src_target(src_target)
);

// File: tb/sft_arbiter_tb.sv
module sft_arbiter_tb;
    localparam int W   = 5;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cpu_target = '0;
    logic [W-1:0] src_target = '0;
    logic         mode_manual = 1'b0;
    logic         manual_sel = 1'b0;
    logic         rate_tick = 1'b0;
    logic [W-1:0] cpu_live;
    logic [W-1:0] src_live;
    logic         busy;

    int checks = 0;
    int errors = 0;
    int exp_cpu = 0;
    int exp_src = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sft_arbiter #(.N_W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cpu_target (cpu_target),
        .src_target (src_target),
        .mode_manual(mode_manual),
        .manual_sel (manual_sel),
        .rate_tick  (rate_tick),
        .cpu_live   (cpu_live),
        .src_live   (src_live),
        .busy       (busy)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int ec, input int es, input int eb);
        chk(cpu_live == W'(ec), {req, " cpu_live"}, int'(cpu_live), ec);
        chk(src_live == W'(es), {req, " src_live"}, int'(src_live), es);
        chk(busy == eb[0], {req, " busy"}, int'(busy), eb);
    endtask

    // CPU-owned ramp with a tick on every clock; checks each step (R2, R3)
    task automatic ramp_cpu(input int b);
        int a = exp_cpu;
        int d = (b > a) ? b - a : a - b;
        int dir = (b > a) ? 1 : -1;
        cpu_target = W'(b);
        rate_tick  = 1'b1;
        if (d == 0) begin
            step();
            chk_all("R11", a, exp_src, 0);
        end
        for (int k = 1; k <= d; k++) begin
            step();
            chk_all("R2_R3", a + dir * k, exp_src, (k < d) ? 1 : 0);
        end
        exp_cpu = b;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk_all("R1", 0, 0, 0);

        // Exhaustive CPU ramp over every start/end pair, automatic mode
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                ramp_cpu(a);
                ramp_cpu(b);
            end
        end

        // R4: no step without a tick
        ramp_cpu(10);
        cpu_target = W'(15);
        rate_tick  = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk_all("R4", 10, exp_src, 1);
        end
        rate_tick = 1'b1; step(); chk_all("R4 tick", 11, exp_src, 1);
        rate_tick = 1'b0; step(); chk_all("R4 idle", 11, exp_src, 1);
        rate_tick = 1'b1; step(); chk_all("R4 tick", 12, exp_src, 1);

        // R10: retarget downward mid-ramp
        cpu_target = W'(9);
        for (int k = 1; k <= 3; k++) begin
            step();
            chk_all("R10", 12 - k, exp_src, (k < 3) ? 1 : 0);
        end
        exp_cpu = 9;

        // R5: only SRC changes in automatic mode -> SRC ramps
        src_target = W'(4);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk_all("R5", exp_cpu, k, (k < 4) ? 1 : 0);
        end
        exp_src = 4;

        // R6: both change together -> CPU ramps, SRC jumps
        rate_tick  = 1'b0;
        cpu_target = W'(12);
        src_target = W'(20);
        step();
        chk_all("R6", 9, 20, 1);
        exp_src = 20;
        rate_tick = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            step();
            chk_all("R6", 9 + k, 20, (k < 3) ? 1 : 0);
        end
        exp_cpu = 12;

        // R7: SRC changes while CPU is ramping -> SRC jumps next edge
        cpu_target = W'(2);
        step();
        chk_all("R7", 11, 20, 1);
        src_target = W'(30);
        step();
        chk_all("R7", 10, 30, 1);
        exp_src = 30;
        for (int k = 9; k >= 2; k--) step();
        chk_all("R7 end", 2, 30, 0);
        exp_cpu = 2;

        // R9: manual mode, SRC selected
        mode_manual = 1'b1;
        manual_sel  = 1'b1;
        cpu_target  = W'(25);
        step();
        chk_all("R9 cpu abrupt", 25, 30, 0);
        exp_cpu = 25;
        src_target = W'(27);
        for (int k = 1; k <= 3; k++) begin
            step();
            chk_all("R9 src ramp", 25, 30 - k, (k < 3) ? 1 : 0);
        end
        exp_src = 27;

        // R8: flip manual_sel and mode while SRC ramps; engine stays with SRC
        src_target = W'(31);
        step();
        chk_all("R8", 25, 28, 1);
        manual_sel  = 1'b0;
        mode_manual = 1'b0;
        cpu_target  = W'(5);
        step();
        chk_all("R8", 5, 29, 1);
        step();
        chk_all("R8", 5, 30, 1);
        step();
        chk_all("R8", 5, 31, 0);
        exp_cpu = 5;
        exp_src = 31;

        // R9: manual CPU selected, SRC abrupt
        mode_manual = 1'b1;
        manual_sel  = 1'b0;
        src_target  = W'(0);
        step();
        chk_all("R9 src abrupt", 5, 0, 0);
        exp_src = 0;
        cpu_target = W'(7);
        step(); chk_all("R9 cpu ramp", 6, 0, 1);
        step(); chk_all("R9 cpu ramp", 7, 0, 0);

        // R11: target equal to live in manual mode
        cpu_target = W'(7);
        step();
        chk_all("R11", 7, 0, 0);

        // R1: reset again mid-ramp
        cpu_target = W'(20);
        step();
        rst = 1'b1;
        step();
        chk_all("R1 rerun", 0, 0, 0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule